// File: doc/BRIEF.md
# Display-Priority Video Memory Slot Arbiter

This block owns the single port of an asynchronous 16-bit video SRAM and shares it between two clients: the display scan-out, which must receive one pixel word every 40 ns, and a host bridge, which can wait. The controller runs at 50 MHz and cuts time into fixed two-cycle slots, so one slot matches one 25 MHz pixel period. The scan-out side raises `disp_active` while it needs pixels. While that signal is high at a slot boundary, the slot is always a display read. Host traffic only gets slots that fall in horizontal or vertical blanking.

The host side has a one-entry buffer. A request is latched when the buffer is empty, and `host_busy` stays high until the matching `host_ack`. Read data comes back with the acknowledge. The display side sees a `disp_grant` strobe at each slot boundary where its address is taken. The fetched word returns as three 4-bit colour channels with a one-cycle `disp_valid`.

The sequencer has eight states, grouped as four slot kinds with a first and a second cycle each: IDLE_A/IDLE_B, DISP_A/DISP_B, HRD_A/HRD_B (host read) and HWR_A/HWR_B (host write). Each A state always moves to its B state. From every B state the controller chooses the next slot:
- DISP_A if `disp_active` is high.
- Otherwise HWR_A or HRD_A if a host request is pending and it is not the one finishing now.
- Otherwise IDLE_A.

Reset enters IDLE_A.

Top module: `vram_slot_arbiter`

## Requirements
- R1: While reset is asserted and right after it, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are 1, `sram_drive` is 0, and `host_busy`, `host_ack` and `disp_valid` are 0.
- R2: Every SRAM access lasts exactly two cycles. Whenever `sram_oe_n` is 0, `sram_ce_n` is 0, `sram_we_n` is 1 and `sram_drive` is 0.
- R3: A `disp_grant` in cycle c makes `disp_valid` high in cycle c+3, carrying the SRAM word at the address that was on `disp_addr` in cycle c. While `disp_active` stays high, `disp_valid` alternates every cycle.
- R4: While `disp_active` is high at a slot boundary, no host slot starts. A pending host request gets no acknowledge and no write strobe, and the display pace is unchanged.
- R5: `host_req` is accepted only when `host_busy` is 0. A request made while busy is ignored and leaves memory unchanged.
- R6: In a host write, `sram_we_n` is 0 only in the second cycle of the slot. `sram_ce_n` is 0 and `sram_drive` is 1 in both cycles, and `sram_addr` and `sram_wdata` are the same in both cycles.
- R7: For a host read, `host_rdata` equals the SRAM word at `host_addr` during the `host_ack` cycle.
- R8: `host_ack` is a single-cycle pulse, with one pulse per accepted request. `host_busy` falls with it. In blanking, the pulse comes at most 6 cycles after the request.
- R9: `pix_red` is word bits 11..8, `pix_green` is bits 7..4 and `pix_blue` is bits 3..0. Bit 3 of each channel is its most significant bit, and word bits 15..12 have no effect.
- R10: With no display need and no pending request, every slot is idle and `sram_ce_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_active | input | 1 | Scan-out needs pixels (active video) |
| disp_addr | input | ADDR_W | Word address of the next pixel |
| disp_grant | output | 1 | `disp_addr` is taken at the coming edge |
| disp_valid | output | 1 | Pixel channels carry a fetched word |
| pix_red | output | 4 | Red channel, bit 3 MSB |
| pix_green | output | 4 | Green channel, bit 3 MSB |
| pix_blue | output | 4 | Blue channel, bit 3 MSB |
| host_req | input | 1 | Host request strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | DATA_W | Host write data |
| host_busy | output | 1 | Request buffer occupied |
| host_ack | output | 1 | Request completed (one cycle) |
| host_rdata | output | DATA_W | Read data, valid with `host_ack` |
| sram_addr | output | ADDR_W | SRAM address |
| sram_wdata | output | DATA_W | Data driven onto the SRAM bus |
| sram_drive | output | 1 | Output enable for the data bus pads |
| sram_rdata | input | DATA_W | Data from the SRAM bus |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |

## Verification
The bench builds the block with ADDR_W = 6 and DATA_W = 16. That leaves a 64-word memory, small enough to write and read back every address through the host port and to scan it in full through the display path more than once. The stored words have their top four bits set, so any leak of those bits into the colour channels shows up. Active and blanking windows alternate in short runs, so the bench reaches host requests that wait through active video, requests rejected while the buffer is full, and slot boundaries where display and host contend.

// File: rtl/vram_arb_pkg.sv
`timescale 1ns/1ps
package vram_arb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE_A,
        ST_IDLE_B,
        ST_DISP_A,
        ST_DISP_B,
        ST_HRD_A,
        ST_HRD_B,
        ST_HWR_A,
        ST_HWR_B
    } slot_state_e;

    localparam int CHAN_W   = 4;
    localparam int NUM_CHAN = 3;
    localparam int COLOUR_W = CHAN_W * NUM_CHAN;

endpackage

// File: rtl/vram_slot_fsm.sv
`timescale 1ns/1ps
module vram_slot_fsm
    import vram_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic disp_active,
    input  logic host_pending,
    input  logic host_we,
    output logic slot_edge,
    output logic host_slot,
    output logic disp_done,
    output logic host_done,
    output logic ce_n,
    output logic oe_n,
    output logic we_n,
    output logic drive
);

    slot_state_e state, state_nx;
    logic        host_wants;

    // Host request counts only if it is not the one finishing in this slot
    assign host_wants = host_pending && !host_done;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE_A: state_nx = ST_IDLE_B;
            ST_DISP_A: state_nx = ST_DISP_B;
            ST_HRD_A:  state_nx = ST_HRD_B;
            ST_HWR_A:  state_nx = ST_HWR_B;
            ST_IDLE_B, ST_DISP_B, ST_HRD_B, ST_HWR_B: begin
                if (disp_active)     state_nx = ST_DISP_A;
                else if (host_wants) state_nx = host_we ? ST_HWR_A : ST_HRD_A;
                else                 state_nx = ST_IDLE_A;
            end
            default: state_nx = ST_IDLE_A;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE_A;
        else        state <= state_nx;
    end

    always_comb begin
        slot_edge = 1'b0;
        host_slot = 1'b0;
        disp_done = 1'b0;
        host_done = 1'b0;
        ce_n      = 1'b1;
        oe_n      = 1'b1;
        we_n      = 1'b1;
        drive     = 1'b0;
        unique case (state)
            ST_IDLE_A: ;
            ST_IDLE_B: slot_edge = 1'b1;
            ST_DISP_A: begin
                ce_n = 1'b0;
                oe_n = 1'b0;
            end
            ST_DISP_B: begin
                ce_n      = 1'b0;
                oe_n      = 1'b0;
                slot_edge = 1'b1;
                disp_done = 1'b1;
            end
            ST_HRD_A: begin
                ce_n      = 1'b0;
                oe_n      = 1'b0;
                host_slot = 1'b1;
            end
            ST_HRD_B: begin
                ce_n      = 1'b0;
                oe_n      = 1'b0;
                host_slot = 1'b1;
                slot_edge = 1'b1;
                host_done = 1'b1;
            end
            ST_HWR_A: begin
                ce_n      = 1'b0;
                drive     = 1'b1;
                host_slot = 1'b1;
            end
            ST_HWR_B: begin
                ce_n      = 1'b0;
                we_n      = 1'b0;
                drive     = 1'b1;
                host_slot = 1'b1;
                slot_edge = 1'b1;
                host_done = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/vram_host_buffer.sv
`timescale 1ns/1ps
module vram_host_buffer #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done,
    input  logic [DATA_W-1:0] sram_rdata,
    output logic              pending,
    output logic              we_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            ack     <= 1'b0;
            rdata   <= '0;
        end else begin
            ack <= 1'b0;
            if (done) begin
                pending <= 1'b0;
                ack     <= 1'b1;
                if (!we_q) rdata <= sram_rdata;
            end else if (req && !pending) begin
                pending <= 1'b1;
                we_q    <= we;
                addr_q  <= addr;
                wdata_q <= wdata;
            end
        end
    end

endmodule

// File: rtl/vram_pixel_unpack.sv
`timescale 1ns/1ps
module vram_pixel_unpack
    import vram_arb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  logic [COLOUR_W-1:0] word_in,
    output logic                valid,
    output logic [CHAN_W-1:0]   red,
    output logic [CHAN_W-1:0]   green,
    output logic [CHAN_W-1:0]   blue
);

    logic [COLOUR_W-1:0] word_q;
    logic [CHAN_W-1:0]   chan [NUM_CHAN];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            word_q <= '0;
        end else begin
            valid <= capture;
            if (capture) word_q <= word_in;
        end
    end

    // Channel k takes bits [k*CHAN_W +: CHAN_W]; index order kept, MSB stays MSB
    for (genvar k = 0; k < NUM_CHAN; k++) begin : g_chan
        assign chan[k] = word_q[k*CHAN_W +: CHAN_W];
    end

    assign blue  = chan[0];
    assign green = chan[1];
    assign red   = chan[2];

endmodule

// File: rtl/vram_slot_arbiter.sv
`timescale 1ns/1ps
module vram_slot_arbiter
    import vram_arb_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_active,
    input  logic [ADDR_W-1:0] disp_addr,
    output logic              disp_grant,
    output logic              disp_valid,
    output logic [3:0]        pix_red,
    output logic [3:0]        pix_green,
    output logic [3:0]        pix_blue,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_busy,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_wdata,
    output logic              sram_drive,
    input  logic [DATA_W-1:0] sram_rdata,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n
);

    logic              slot_edge;
    logic              host_slot;
    logic              disp_done;
    logic              host_done;
    logic              hb_we;
    logic [ADDR_W-1:0] hb_addr;
    logic [DATA_W-1:0] hb_wdata;
    logic [ADDR_W-1:0] disp_addr_q;

    vram_slot_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .disp_active  (disp_active),
        .host_pending (host_busy),
        .host_we      (hb_we),
        .slot_edge    (slot_edge),
        .host_slot    (host_slot),
        .disp_done    (disp_done),
        .host_done    (host_done),
        .ce_n         (sram_ce_n),
        .oe_n         (sram_oe_n),
        .we_n         (sram_we_n),
        .drive        (sram_drive)
    );

    vram_host_buffer #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (host_req),
        .we         (host_we),
        .addr       (host_addr),
        .wdata      (host_wdata),
        .done       (host_done),
        .sram_rdata (sram_rdata),
        .pending    (host_busy),
        .we_q       (hb_we),
        .addr_q     (hb_addr),
        .wdata_q    (hb_wdata),
        .ack        (host_ack),
        .rdata      (host_rdata)
    );

    vram_pixel_unpack u_pix (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (disp_done),
        .word_in (sram_rdata[COLOUR_W-1:0]),
        .valid   (disp_valid),
        .red     (pix_red),
        .green   (pix_green),
        .blue    (pix_blue)
    );

    assign disp_grant = slot_edge && disp_active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          disp_addr_q <= '0;
        else if (disp_grant) disp_addr_q <= disp_addr;
    end

    assign sram_addr  = host_slot ? hb_addr : disp_addr_q;
    assign sram_wdata = hb_wdata;

endmodule

// File: rtl/vram_arb_checker.sv
`timescale 1ns/1ps
module vram_arb_checker #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              disp_active,
    input logic              disp_grant,
    input logic              disp_valid,
    input logic              host_busy,
    input logic              host_ack,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [DATA_W-1:0] sram_wdata,
    input logic              sram_drive,
    input logic              sram_ce_n,
    input logic              sram_oe_n,
    input logic              sram_we_n
);

    assert_read_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (!sram_ce_n && sram_we_n && !sram_drive));

    assert_grant_to_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        disp_grant |-> ##3 disp_valid);

    assert_valid_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> !disp_valid);

    assert_no_write_in_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> !$past(disp_active, 2));

    assert_busy_until_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_busy) |-> host_ack);

    assert_we_second_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> ($past(sram_we_n) && !$past(sram_ce_n) && $past(sram_drive)
                        && $stable(sram_addr) && $stable(sram_wdata)));

    assert_ack_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

endmodule

bind vram_slot_arbiter vram_arb_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .disp_active (disp_active),
    .disp_grant  (disp_grant),
    .disp_valid  (disp_valid),
    .host_busy   (host_busy),
    .host_ack    (host_ack),
    .sram_addr   (sram_addr),
    .sram_wdata  (sram_wdata),
    .sram_drive  (sram_drive),
    .sram_ce_n   (sram_ce_n),
    .sram_oe_n   (sram_oe_n),
    .sram_we_n   (sram_we_n)
);

// File: tb/tb_vram_slot_arbiter.sv
`timescale 1ns/1ps
module tb_vram_slot_arbiter;

    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          disp_active = 1'b0;
    logic [AW-1:0] disp_addr = '0;
    logic          disp_grant, disp_valid;
    logic [3:0]    pix_red, pix_green, pix_blue;
    logic          host_req = 1'b0, host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_busy, host_ack;
    logic [DW-1:0] host_rdata;
    logic [AW-1:0] sram_addr;
    logic [DW-1:0] sram_wdata, sram_rdata;
    logic          sram_drive, sram_ce_n, sram_oe_n, sram_we_n;

    logic [DW-1:0] mem     [DEPTH];
    logic [DW-1:0] ref_mem [DEPTH];

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int we_pulses = 0;
    int ack_pulses = 0;

    always #10 clk = ~clk;

    vram_slot_arbiter #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .disp_active(disp_active), .disp_addr(disp_addr),
        .disp_grant(disp_grant), .disp_valid(disp_valid),
        .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_busy(host_busy), .host_ack(host_ack),
        .host_rdata(host_rdata),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_drive(sram_drive),
        .sram_rdata(sram_rdata), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n)
    );

    // Asynchronous SRAM model
    assign sram_rdata = mem[sram_addr];
    always @(posedge clk)
        if (!sram_we_n && !sram_ce_n && sram_drive) mem[sram_addr] <= sram_wdata;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [DW-1:0] seed_word(input int a);
        return 16'hF000 | DW'((a * 16'h0259 + 16'h0A5) & 16'h0FFF);
    endfunction

    // Display-side model: expected address queue, pixel and pacing checks
    int       q_addr [256];
    int       q_wr = 0, q_rd = 0;
    bit       inc_pend = 1'b0;
    int       act_run = 0;
    logic     prev_valid = 1'b0;
    logic     prev_ce_n = 1'b1, prev_we_n = 1'b1, prev_drive = 1'b0, prev_ack = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    logic [DW-1:0] prev_wdata = '0;
    int       ce_run = 0;

    always @(negedge clk) begin
        cyc++;
        if (inc_pend) begin
            disp_addr = disp_addr + 1'b1;
            inc_pend  = 1'b0;
        end
        if (rst_n) begin
            if (disp_grant) begin
                q_addr[q_wr % 256] = int'(disp_addr);
                q_wr++;
                inc_pend = 1'b1;
            end
            if (disp_valid) begin
                logic [DW-1:0] e;
                e = ref_mem[q_addr[q_rd % 256]];
                q_rd++;
                // R3 data of the granted address, R9 channel split (bits 15..12 ignored)
                check({pix_red, pix_green, pix_blue} == e[11:0], "R3/R9 pixel",
                      int'({pix_red, pix_green, pix_blue}), int'(e[11:0]));
            end
            // R3/R4: steady pace while active
            act_run = disp_active ? act_run + 1 : 0;
            if (act_run >= 5)
                check(disp_valid != prev_valid, "R3/R4 pixel pace", disp_valid, !prev_valid);
            // R2 read strobes
            if (!sram_oe_n)
                check(sram_we_n && !sram_drive && !sram_ce_n, "R2 read strobes",
                      {sram_we_n, sram_drive}, 2'b10);
            // R2 access length: each chip-enable run is a whole number of slots
            if (!sram_ce_n) ce_run++;
            else begin
                if (ce_run != 0) check(ce_run % 2 == 0, "R2 slot length", ce_run, 2);
                ce_run = 0;
            end
            // R6 write strobe shape
            if (!sram_we_n) begin
                we_pulses++;
                check(!prev_ce_n && prev_we_n && prev_drive && sram_drive &&
                      prev_addr == sram_addr && prev_wdata == sram_wdata,
                      "R6 write strobe shape", int'(sram_addr), int'(prev_addr));
            end
            // R8 single-cycle ack
            if (host_ack) begin
                ack_pulses++;
                check(!prev_ack, "R8 ack width", 2, 1);
                check(!host_busy, "R8 busy falls with ack", host_busy, 0);
            end
        end
        prev_valid = disp_valid;
        prev_ce_n  = sram_ce_n;
        prev_we_n  = sram_we_n;
        prev_drive = sram_drive;
        prev_addr  = sram_addr;
        prev_wdata = sram_wdata;
        prev_ack   = host_ack;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Issue one host operation; returns latency to ack (-1 if none within limit)
    task automatic host_op(input bit we, input int a, input logic [DW-1:0] d,
                           input int limit, output int lat, output logic [DW-1:0] rd);
        lat = -1;
        rd  = '0;
        while (host_busy) @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = AW'(a); host_wdata = d;
        @(negedge clk);
        host_req = 1'b0;
        for (int i = 1; i <= limit; i++) begin
            if (host_ack) begin
                lat = i;
                rd  = host_rdata;
                break;
            end
            @(negedge clk);
        end
        if (lat > 0 && we) ref_mem[a] = d;
    endtask

    task automatic display_sweep(input int cycles);
        disp_addr   = '0;
        disp_active = 1'b1;
        repeat (cycles) @(negedge clk);
        disp_active = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        int lat;
        logic [DW-1:0] rd;
        int acks_before, we_before;

        for (int i = 0; i < DEPTH; i++) begin
            mem[i]     = seed_word(i);
            ref_mem[i] = seed_word(i);
        end

        // R1 reset state
        repeat (3) @(negedge clk);
        check(sram_ce_n && sram_oe_n && sram_we_n && !sram_drive, "R1 strobes in reset",
              {sram_ce_n, sram_oe_n, sram_we_n, sram_drive}, 4'b1110);
        check(!host_busy && !host_ack && !disp_valid, "R1 flags in reset",
              {host_busy, host_ack, disp_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sram_ce_n && !host_busy && !disp_valid, "R1 after reset",
              {sram_ce_n, host_busy, disp_valid}, 3'b100);

        // R10 idle slots
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check(sram_ce_n && !disp_grant, "R10 idle", sram_ce_n, 1);
        end

        // R3/R9 full display sweep of the seeded memory
        display_sweep(2 * DEPTH + 20);
        check(q_rd == q_wr && q_rd >= DEPTH, "R3 every grant returned", q_rd, q_wr);

        // R4/R5: host write held off during active video; second request ignored
        disp_addr   = '0;
        disp_active = 1'b1;
        repeat (4) @(negedge clk);
        acks_before = ack_pulses;
        we_before   = we_pulses;
        host_req = 1'b1; host_we = 1'b1; host_addr = AW'(5); host_wdata = 16'h0ABC;
        @(negedge clk);
        host_req = 1'b0;
        check(host_busy, "R5 request accepted", host_busy, 1);
        repeat (3) @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = AW'(6); host_wdata = 16'h0DEF;
        @(negedge clk);
        host_req = 1'b0;
        repeat (40) @(negedge clk);
        check(ack_pulses == acks_before, "R4 no ack in active", ack_pulses, acks_before);
        check(we_pulses == we_before, "R4 no write in active", we_pulses, we_before);
        check(host_busy, "R4 still pending", host_busy, 1);
        disp_active = 1'b0;
        lat = -1;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (host_ack) begin lat = i; break; end
        end
        check(lat > 0, "R8 ack after active ends", lat, 6);
        if (lat > 0) ref_mem[5] = 16'h0ABC;
        repeat (4) @(negedge clk);
        check(ack_pulses == acks_before + 1, "R8 one ack per request", ack_pulses, acks_before + 1);
        host_op(1'b0, 6, '0, 20, lat, rd);
        check(rd == ref_mem[6], "R5 busy request ignored", int'(rd), int'(ref_mem[6]));
        host_op(1'b0, 5, '0, 20, lat, rd);
        check(rd == 16'h0ABC, "R7 read back held write", int'(rd), 16'h0ABC);

        // Exhaustive host write then read in blanking (R6, R7, R8)
        for (int a = 0; a < DEPTH; a++) begin
            host_op(1'b1, a, DW'((a * 16'h1357) ^ 16'hC3A5), 20, lat, rd);
            check(lat > 0 && lat <= 6, "R8 write ack latency", lat, 6);
        end
        for (int a = 0; a < DEPTH; a++) begin
            host_op(1'b0, a, '0, 20, lat, rd);
            check(lat > 0 && lat <= 6, "R8 read ack latency", lat, 6);
            check(rd == ref_mem[a], "R7 read data", int'(rd), int'(ref_mem[a]));
        end

        // R9/R3 display sweep of the written words (top bits vary)
        display_sweep(2 * DEPTH + 20);

        // Mixed: active/blank windows with host reads contending
        fork
            begin
                disp_addr = '0;
                for (int w = 0; w < 12; w++) begin
                    disp_active = 1'b1;
                    repeat (10 + 2 * (w % 3)) @(negedge clk);
                    disp_active = 1'b0;
                    repeat (5 + (w % 4)) @(negedge clk);
                end
            end
            begin
                for (int k = 0; k < 20; k++) begin
                    host_op(1'b0, (k * 7) % DEPTH, '0, 200, lat, rd);
                    check(lat > 0, "R8 ack in mixed traffic", lat, 1);
                    check(rd == ref_mem[(k * 7) % DEPTH], "R7 mixed read",
                          int'(rd), int'(ref_mem[(k * 7) % DEPTH]));
                end
            end
        join
        disp_active = 1'b0;
        repeat (10) @(negedge clk);
        check(q_rd == q_wr, "R3 all grants returned", q_rd, q_wr);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule